// File: doc/BRIEF.md
# Programmable-Logic Configuration Sequencer

This block steers a programmable-logic target through its configuration life cycle. Software writes a control register that enables the sequencer, drives the target's active-low chip enable and pulls the target's configuration line into reset. It then reads a status register that reports the current phase together with the mode-select strap pins. The phase advances from control writes and from the target's handshake lines:

- pulling the line enters reset;
- releasing it enters configuration;
- a good handshake enters a fixed-length init phase, which ends in user mode.

A separate write-only data port takes one configuration word per write and sends it to the target over a simple parallel bus. In 32-bit mode a word goes out as one beat. In 16-bit mode it goes out as two beats. Each beat is held for 1, 2, 4 or 8 clock cycles, and a strobe marks the start of each beat. A busy flag tells the writer to wait before sending the next word. The target is represented only by its power-good, status and done lines.

Top module: `plcfg_ctrl`

## Requirements
- R1: After reset the control register reads 0x002 (only the chip-enable-off bit set), the phase reads 0, `dat_busy` is 0, `tgt_nconfig` is 1 and `tgt_nce` is 1.
- R2: The status register at byte offset 0x0 returns the phase in bits [2:0] and the mode-select pins in bits [7:3]. The pins are registered, so bits [7:3] show the pin value from the previous clock edge. All higher bits read 0.
- R3: The control register at offset 0x4 holds these fields: enable in bit 0, chip-enable-off in bit 1, pull in bit 2, ratio in bits [7:6], data-port enable in bit 8 and wide mode in bit 9. Any other bit reads 0. Writes to offset 0x0 have no effect. Offsets 0x8 and 0xC read 0.
- R4: While `tgt_pwr_on` is low the status phase field reads 0 in the same cycle. A power loss returns the sequencer to phase 0, where it stays after power returns until the next pull.
- R5: Phase codes are 0 power-up, 1 reset, 2 configuration, 3 init, 4 user and 5 unknown. When both enable and pull are set, `tgt_nconfig` goes low at once and the phase becomes 1 one cycle later. Pull without enable does nothing.
- R6: When the hold is released while in reset, the phase becomes 2 at the next clock edge after the release takes effect.
- R7: In configuration, if done and status are both high, the phase becomes 3. It stays 3 for INIT_CYCLES cycles (default 4) and then becomes 4.
- R8: In configuration, if done is high while status is low, the phase becomes 5 and stays there.
- R9: A data-port write while the data-port enable bit is clear is ignored: `dat_busy`, `cfg_dclk` and `cfg_data` stay 0.
- R10: An accepted word keeps `dat_busy` high for beats × 2^ratio cycles, starting the cycle after the write. `cfg_dclk` is high in the first cycle of each beat only.
- R11: In wide mode a word goes out as one beat carrying all 32 bits. In narrow mode it goes out as two beats: bits [15:0] first, then bits [31:16], each on `cfg_data[15:0]` with the upper half zero. `cfg_data` is 0 when the port is idle.
- R12: Data-port writes that arrive while `dat_busy` is high are dropped. They do not change the data sent or the busy length.
- R13: `tgt_nce` always equals control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| dat_wr | input | 1 | Data-port write strobe |
| dat_wdata | input | 32 | Configuration word |
| dat_busy | output | 1 | Word in flight; further writes dropped |
| msel_pins | input | 5 | Mode-select strap pins |
| tgt_pwr_on | input | 1 | Target power-good monitor |
| tgt_nstatus | input | 1 | Target status line (high = no error) |
| tgt_conf_done | input | 1 | Target done line |
| tgt_nconfig | output | 1 | Active-low reset request to target |
| tgt_nce | output | 1 | Active-low chip enable to target |
| cfg_dclk | output | 1 | Beat strobe |
| cfg_data | output | 32 | Beat data |

## Verification
Two situations are hard to reach from the ports.

The first is the init countdown and the error exit. Both need the phase walked through reset and configuration first, using control writes and handshake levels that are set at exactly the right cycles. The stimulus therefore replays the full pull, release and handshake sequence before each of these checks.

The second is a dropped write, which needs a data-port write to land inside a word that is still being sent. During the sweep over all ratios and both widths, a second word is injected in the second busy cycle. Every cycle of the beat pattern is then compared against the arithmetic expectation for the first word only.

// File: rtl/plcfg_pkg.sv
`timescale 1ns/1ps
// Shared types for the configuration sequencer: phase codes and control fields.
package plcfg_pkg;
    typedef enum logic [2:0] {
        PH_POWERUP = 3'd0,
        PH_RESET   = 3'd1,
        PH_CONFIG  = 3'd2,
        PH_INIT    = 3'd3,
        PH_USER    = 3'd4,
        PH_UNKNOWN = 3'd5
    } phase_e;

    typedef struct packed {
        logic       wide;
        logic       port_en;
        logic [1:0] ratio;
        logic       pull;
        logic       nce;
        logic       en;
    } ctrl_t;

    localparam int BIT_EN    = 0;
    localparam int BIT_NCE   = 1;
    localparam int BIT_PULL  = 2;
    localparam int RATIO_LO  = 6;
    localparam int BIT_PORT  = 8;
    localparam int BIT_WIDE  = 9;
    localparam int REG_W     = 32;
endpackage

// File: rtl/plcfg_regs.sv
`timescale 1ns/1ps
// Register file: control register storage, mode-pin sampling and read mux.
// Assumes byte addresses; status at 0x0, control at 0x4, all else reads zero.
module plcfg_regs #(
    parameter int ADDR_W = 4,
    parameter int MSEL_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [plcfg_pkg::REG_W-1:0] bus_wdata,
    output logic [plcfg_pkg::REG_W-1:0] bus_rdata,
    input  logic [MSEL_W-1:0]           msel_pins,
    input  logic [2:0]                  phase_vis,
    output plcfg_pkg::ctrl_t            ctrl
);
    import plcfg_pkg::*;
    localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(4);

    logic [MSEL_W-1:0] msel_q;
    logic              unused_wbits;

    assign unused_wbits = ^{bus_wdata[REG_W-1:BIT_WIDE+1], bus_wdata[RATIO_LO-1:BIT_PULL+1]};

    // Control register write and mode-pin sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '{wide: 1'b0, port_en: 1'b0, ratio: 2'd0, pull: 1'b0, nce: 1'b1, en: 1'b0};
            msel_q <= '0;
        end else begin
            msel_q <= msel_pins;
            if (bus_wr && bus_addr == CTRL_OFS) begin
                ctrl.en      <= bus_wdata[BIT_EN];
                ctrl.nce     <= bus_wdata[BIT_NCE];
                ctrl.pull    <= bus_wdata[BIT_PULL];
                ctrl.ratio   <= bus_wdata[RATIO_LO +: 2];
                ctrl.port_en <= bus_wdata[BIT_PORT];
                ctrl.wide    <= bus_wdata[BIT_WIDE];
            end
        end
    end

    // Read data selection.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STAT_OFS) begin
            bus_rdata[2:0]        = phase_vis;
            bus_rdata[3 +: MSEL_W] = msel_q;
        end else if (bus_addr == CTRL_OFS) begin
            bus_rdata[BIT_EN]        = ctrl.en;
            bus_rdata[BIT_NCE]       = ctrl.nce;
            bus_rdata[BIT_PULL]      = ctrl.pull;
            bus_rdata[RATIO_LO +: 2] = ctrl.ratio;
            bus_rdata[BIT_PORT]      = ctrl.port_en;
            bus_rdata[BIT_WIDE]      = ctrl.wide;
        end
    end
endmodule

// File: rtl/plcfg_phase.sv
`timescale 1ns/1ps
// Phase sequencer: tracks power-up, reset, configuration, init, user and error.
// Assumes handshake inputs are already synchronous to clk.
module plcfg_phase #(
    parameter int INIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              hold,
    input  logic              conf_done,
    input  logic              nstatus,
    output plcfg_pkg::phase_e phase_q
);
    import plcfg_pkg::*;
    localparam int CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Phase transitions and init countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_POWERUP;
            cnt_q   <= '0;
        end else if (!pwr_on) begin
            phase_q <= PH_POWERUP;
            cnt_q   <= '0;
        end else if (hold) begin
            phase_q <= PH_RESET;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_RESET:  phase_q <= PH_CONFIG;
                PH_CONFIG: begin
                    cnt_q <= '0;
                    if (conf_done) phase_q <= nstatus ? PH_INIT : PH_UNKNOWN;
                end
                PH_INIT: begin
                    if (cnt_q == CNT_LAST) phase_q <= PH_USER;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end
                default: phase_q <= phase_q;
            endcase
        end
    end
endmodule

// File: rtl/plcfg_serial.sv
`timescale 1ns/1ps
// Data-port serialiser: sends one word as one wide or two narrow beats, each
// held for 2^ratio cycles. Width and ratio are latched when the word is taken.
module plcfg_serial #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              port_en,
    input  logic              wide,
    input  logic [1:0]        ratio,
    output logic              busy,
    output logic              dclk,
    output logic [DATA_W-1:0] data
);
    localparam int HALF = DATA_W / 2;

    logic              busy_q, beat_q, wide_q, accept, last_beat;
    logic [2:0]        cyc_q, lim_q, lim_new;
    logic [DATA_W-1:0] word_q;

    assign accept    = wr && port_en && !busy_q;
    assign last_beat = wide_q || beat_q;

    // Cycles per beat minus one, from the ratio field.
    always_comb begin
        case (ratio)
            2'd0:    lim_new = 3'd0;
            2'd1:    lim_new = 3'd1;
            2'd2:    lim_new = 3'd3;
            default: lim_new = 3'd7;
        endcase
    end

    // Word capture and beat/cycle stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            beat_q <= 1'b0;
            wide_q <= 1'b0;
            cyc_q  <= '0;
            lim_q  <= '0;
            word_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            beat_q <= 1'b0;
            wide_q <= wide;
            cyc_q  <= '0;
            lim_q  <= lim_new;
            word_q <= wdata;
        end else if (busy_q) begin
            if (cyc_q == lim_q) begin
                cyc_q <= '0;
                if (last_beat) busy_q <= 1'b0;
                else           beat_q <= 1'b1;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    // Beat data and strobe.
    always_comb begin
        data = '0;
        if (busy_q) begin
            if (wide_q) data = word_q;
            else        data[HALF-1:0] = beat_q ? word_q[DATA_W-1:HALF] : word_q[HALF-1:0];
        end
    end

    assign busy = busy_q;
    assign dclk = busy_q && (cyc_q == 3'd0);
endmodule

// File: rtl/plcfg_ctrl.sv
`timescale 1ns/1ps
// Configuration sequencer top: registers, phase sequencer and data serialiser.
// Assumes all inputs are synchronous to clk; reads are combinational.
module plcfg_ctrl #(
    parameter int ADDR_W      = 4,
    parameter int MSEL_W      = 5,
    parameter int DATA_W      = 32,
    parameter int INIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic              dat_busy,
    input  logic [MSEL_W-1:0] msel_pins,
    input  logic              tgt_pwr_on,
    input  logic              tgt_nstatus,
    input  logic              tgt_conf_done,
    output logic              tgt_nconfig,
    output logic              tgt_nce,
    output logic              cfg_dclk,
    output logic [DATA_W-1:0] cfg_data
);
    import plcfg_pkg::*;

    ctrl_t      ctrl;
    phase_e     phase_q;
    logic [2:0] phase_vis;
    logic       hold;

    assign hold        = ctrl.en && ctrl.pull;
    assign tgt_nconfig = !hold;
    assign tgt_nce     = ctrl.nce;
    assign phase_vis   = tgt_pwr_on ? phase_q : PH_POWERUP;

    plcfg_regs #(.ADDR_W(ADDR_W), .MSEL_W(MSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msel_pins(msel_pins),
        .phase_vis(phase_vis), .ctrl(ctrl)
    );

    plcfg_phase #(.INIT_CYCLES(INIT_CYCLES)) u_phase (
        .clk(clk), .rst_n(rst_n), .pwr_on(tgt_pwr_on), .hold(hold),
        .conf_done(tgt_conf_done), .nstatus(tgt_nstatus), .phase_q(phase_q)
    );

    plcfg_serial #(.DATA_W(DATA_W)) u_serial (
        .clk(clk), .rst_n(rst_n), .wr(dat_wr), .wdata(dat_wdata),
        .port_en(ctrl.port_en), .wide(ctrl.wide), .ratio(ctrl.ratio),
        .busy(dat_busy), .dclk(cfg_dclk), .data(cfg_data)
    );
endmodule

// File: rtl/plcfg_ctrl_checker.sv
`timescale 1ns/1ps
// Property checker for plcfg_ctrl; attached through bind below.
module plcfg_ctrl_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tgt_pwr_on,
    input logic              tgt_nconfig,
    input logic [2:0]        phase_q,
    input logic              dat_busy,
    input logic              cfg_dclk,
    input logic [DATA_W-1:0] cfg_data
);
    p_pwr_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_pwr_on |=> phase_q == 3'd0);
    p_pull_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_pwr_on && !tgt_nconfig) |=> phase_q == 3'd1);
    p_user_from_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == 3'd4 && $past(phase_q) != 3'd4) |-> $past(phase_q) == 3'd3);
    p_unknown_from_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == 3'd5 && $past(phase_q) != 3'd5) |-> $past(phase_q) == 3'd2);
    p_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dclk |-> dat_busy);
    p_beat_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_busy && !cfg_dclk) |-> $stable(cfg_data));
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_busy |-> cfg_data == '0);
endmodule

bind plcfg_ctrl plcfg_ctrl_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tgt_pwr_on(tgt_pwr_on), .tgt_nconfig(tgt_nconfig),
    .phase_q(phase_q), .dat_busy(dat_busy), .cfg_dclk(cfg_dclk), .cfg_data(cfg_data)
);

// File: tb/plcfg_ctrl_bench.sv
`timescale 1ns/1ps
module plcfg_ctrl_bench;
    localparam int INIT_CYCLES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dat_wr = 1'b0;
    logic [31:0] dat_wdata = '0;
    logic        dat_busy;
    logic [4:0]  msel_pins = '0;
    logic        tgt_pwr_on = 1'b1;
    logic        tgt_nstatus = 1'b0;
    logic        tgt_conf_done = 1'b0;
    logic        tgt_nconfig, tgt_nce, cfg_dclk;
    logic [31:0] cfg_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    plcfg_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_plcfg_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dat_wr(dat_wr),
        .dat_wdata(dat_wdata), .dat_busy(dat_busy), .msel_pins(msel_pins),
        .tgt_pwr_on(tgt_pwr_on), .tgt_nstatus(tgt_nstatus),
        .tgt_conf_done(tgt_conf_done), .tgt_nconfig(tgt_nconfig),
        .tgt_nce(tgt_nce), .cfg_dclk(cfg_dclk), .cfg_data(cfg_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_addr = '0;
        #0.5;
    endtask

    task automatic phase_is(input string req, input logic [2:0] exp);
        rd(4'h0, rv);
        chk(req, {29'd0, rv[2:0]}, {29'd0, exp});
    endtask

    task automatic to_config();
        wr(4'h4, 32'h005);
        wr(4'h4, 32'h001);
        @(negedge clk);
    endtask

    // Send one word and compare every busy cycle; optionally inject a second write.
    task automatic send(input logic [31:0] w, input int ratio, input bit wide, input bit inject);
        int r, nb;
        logic [31:0] exp;
        r  = 1 << ratio;
        nb = wide ? 1 : 2;
        wr(4'h4, 32'h101 | (32'(ratio) << 6) | (32'(wide) << 9));
        @(negedge clk);
        dat_wdata = w; dat_wr = 1'b1;
        @(negedge clk);
        dat_wr = 1'b0;
        for (int i = 0; i < nb * r; i++) begin
            if (wide) exp = w;
            else exp = (i / r == 0) ? {16'd0, w[15:0]} : {16'd0, w[31:16]};
            chk("R10 busy", {31'd0, dat_busy}, 32'd1);
            chk("R10 dclk", {31'd0, cfg_dclk}, {31'd0, (i % r) == 0});
            chk(inject ? "R12 data" : "R11 data", cfg_data, exp);
            if (inject && i == 1) begin dat_wdata = ~w; dat_wr = 1'b1; end
            else dat_wr = 1'b0;
            @(negedge clk);
        end
        dat_wr = 1'b0;
        chk(inject ? "R12 busy end" : "R10 busy end", {31'd0, dat_busy}, 32'd0);
        chk("R11 idle data", cfg_data, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4'h4, rv); chk("R1 ctrl", rv, 32'h002);
        phase_is("R1 phase", 3'd0);
        chk("R1 busy", {31'd0, dat_busy}, 32'd0);
        chk("R1 nconfig", {31'd0, tgt_nconfig}, 32'd1);
        chk("R1 nce", {31'd0, tgt_nce}, 32'd1);

        // R3 field mask, R13 chip enable
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, rv); chk("R3 ctrl mask", rv, 32'h3C7);
        chk("R13 nce set", {31'd0, tgt_nce}, 32'd1);
        wr(4'h4, 32'h0);
        chk("R13 nce clear", {31'd0, tgt_nce}, 32'd0);
        rd(4'h8, rv); chk("R3 addr 8", rv, 32'd0);
        rd(4'hC, rv); chk("R3 addr C", rv, 32'd0);

        // R4 power loss returns to phase 0
        @(negedge clk); tgt_pwr_on = 1'b0;
        @(negedge clk); tgt_pwr_on = 1'b1;
        @(negedge clk);
        phase_is("R4 after power cycle", 3'd0);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, rv); chk("R3 status write ignored", rv, 32'd0);

        // R2 mode-select sweep
        for (int m = 0; m < 32; m++) begin
            msel_pins = 5'(m);
            @(negedge clk);
            rd(4'h0, rv); chk("R2 msel", rv, 32'(m) << 3);
        end
        msel_pins = '0;

        // R5 pull without enable, then with enable
        wr(4'h4, 32'h004);
        chk("R5 nconfig no en", {31'd0, tgt_nconfig}, 32'd1);
        @(negedge clk);
        phase_is("R5 no en phase", 3'd0);
        wr(4'h4, 32'h005);
        chk("R5 nconfig low", {31'd0, tgt_nconfig}, 32'd0);
        @(negedge clk);
        phase_is("R5 reset phase", 3'd1);

        // R6 release
        wr(4'h4, 32'h001);
        phase_is("R6 still reset", 3'd1);
        @(negedge clk);
        phase_is("R6 config", 3'd2);

        // R8 error exit
        tgt_conf_done = 1'b1; tgt_nstatus = 1'b0;
        @(negedge clk);
        phase_is("R8 unknown", 3'd5);
        tgt_conf_done = 1'b0;
        repeat (2) @(negedge clk);
        phase_is("R8 stays unknown", 3'd5);

        // R7 success, init countdown, user
        to_config();
        phase_is("R7 config", 3'd2);
        tgt_conf_done = 1'b1; tgt_nstatus = 1'b1;
        for (int k = 0; k < INIT_CYCLES; k++) begin
            @(negedge clk);
            phase_is("R7 init", 3'd3);
        end
        @(negedge clk);
        phase_is("R7 user", 3'd4);
        repeat (2) @(negedge clk);
        phase_is("R7 user held", 3'd4);

        // R4 immediate power-off view
        tgt_pwr_on = 1'b0;
        phase_is("R4 immediate", 3'd0);
        @(negedge clk); tgt_pwr_on = 1'b1;
        @(negedge clk);
        phase_is("R4 after restore", 3'd0);

        // R9 port disabled
        wr(4'h4, 32'h001);
        dat_wdata = 32'hA5A5_5A5A; dat_wr = 1'b1;
        @(negedge clk); dat_wr = 1'b0;
        chk("R9 busy", {31'd0, dat_busy}, 32'd0);
        chk("R9 dclk", {31'd0, cfg_dclk}, 32'd0);
        chk("R9 data", cfg_data, 32'd0);

        // R10/R11/R12 sweep over ratios and widths
        for (int ra = 0; ra < 4; ra++) begin
            for (int wd = 0; wd < 2; wd++) begin
                send(32'h1234_ABCD ^ (32'(ra) << 20), ra, wd[0], 1'b0);
                send(32'hF00D_0B57 + 32'(ra * 3 + wd), ra, wd[0], 1'b1);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule